// File: doc/BRIEF.md
# OS Timer with Watchdog Compare

The block keeps a free-running 32-bit up-counter. The counter advances by one on every system clock cycle in which a slow reference tick is high. The tick comes from a fixed reference oscillator rather than the processor clock. Four programmable compare registers are each checked for equality against the value the counter is stepping to. A hit sets a sticky per-channel status flag, and software can route that flag to an interrupt line with a per-channel enable.

Channel 3 has a second role as a watchdog. Software arms it through a control register, and once armed it cannot be disarmed except by reset. If the counter then reaches the channel 3 compare value, because software failed to push that value ahead in time, the block raises a reset request. The request stays high until the block itself is reset.

Software reaches everything through a small word-addressed register bus: a write strobe, a 3-bit word address, write data, and read data driven combinationally from the address. The watchdog is a three-state machine:
- `WD_IDLE` is the state after reset.
- `WD_ARMED` is entered from `WD_IDLE` by the transition ARM, a write of 1 to control bit 0.
- `WD_TRIPPED` is entered from `WD_ARMED` by the transition TRIP, a channel 3 hit.
- `WD_TRIPPED` is left only by reset. Every other condition holds the current state.

Top module: `os_timer_wdog`

## Requirements
- R1: After reset the counter reads 0, status reads 0, the interrupt enables read 0, every compare register reads 0xFFFFFFFF, the watchdog control reads 0, `irq` is 0 and `rst_req` is 0.
- R2: The counter (word address 4, read-only) increases by 1 at each clock edge where `tick` is high and holds otherwise. Writes to address 4 leave it unchanged.
- R3: Compare registers for channels 0 to 3 sit at word addresses 0 to 3 and read back the last value written.
- R4: Status bit i (address 5, bits [3:0]) becomes 1 at the clock edge where the counter steps to a value equal to compare register i. It then stays 1 while further ticks occur.
- R5: Writing address 5 clears each status bit whose write-data bit is 1 and leaves bits written 0 untouched. A hit in the same cycle as a clear of that bit leaves the bit set.
- R6: The interrupt enables sit at address 6, bits [3:0]. `irq[i]` is 1 exactly when status bit i and enable bit i are both 1.
- R7: Writing 1 to bit 0 of address 7 arms the watchdog. Writing 0 there never disarms it. Address 7 reads armed in bit 0 and tripped in bit 1. Tripped also reads bit 0 as 1.
- R8: A channel 3 hit while armed raises `rst_req` after that clock edge, and `rst_req` stays high until `rst_n` is asserted. A channel 3 hit while unarmed only sets status bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle reference tick, synchronous to clk |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq | output | 4 | Per-channel interrupt lines |
| rst_req | output | 1 | Watchdog reset request |

## Verification
The bench walks the counter past a compare value and then keeps ticking. A design that compared with "greater or equal", or that flagged only while the count sat on the match value, would show the wrong status there.

It issues a status clear in the very cycle a hit lands. A design that let the clear win would drop an event.

It writes 0 to the watchdog control after arming. A design with an ordinary read/write enable would then stay quiet at the channel 3 hit.

It lets channel 3 hit while unarmed, and holds the clock after a trip. These catch a watchdog that fires without arming, or a request that falls back on its own.

// File: rtl/ostmr_pkg.sv
package ostmr_pkg;

    localparam int NUM_CH = 4;
    localparam int WD_CH  = NUM_CH - 1;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_COUNT  = 3'd4;
    localparam logic [ADDR_W-1:0] A_STATUS = 3'd5;
    localparam logic [ADDR_W-1:0] A_IRQEN  = 3'd6;
    localparam logic [ADDR_W-1:0] A_WDCTL  = 3'd7;

    typedef enum logic [1:0] {
        WD_IDLE    = 2'd0,
        WD_ARMED   = 2'd1,
        WD_TRIPPED = 2'd2
    } wd_state_t;

endpackage

// File: rtl/ostmr_counter.sv
module ostmr_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_nxt
);

    // Incrementer output doubles as the compare operand for every channel.
    assign cnt_nxt = cnt_q + CNT_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= cnt_nxt;   // wraps naturally at all-ones
        end
    end

endmodule

// File: rtl/ostmr_match_ch.sv
module ostmr_match_ch #(
    parameter int               CNT_W     = 32,
    parameter logic [CNT_W-1:0] MATCH_RST = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic [CNT_W-1:0] cnt_nxt,
    input  logic             wr_match,
    input  logic [CNT_W-1:0] wdata,
    input  logic             clr,
    output logic [CNT_W-1:0] match_q,
    output logic             hit,
    output logic             status
);

    // Equality on the value being stepped to: one event per pass.
    assign hit = step && (cnt_nxt == match_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            match_q <= MATCH_RST;
        end else if (wr_match) begin
            match_q <= wdata;
        end
    end

    // A hit outranks a clear so no event is lost.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status <= 1'b0;
        end else if (hit) begin
            status <= 1'b1;
        end else if (clr) begin
            status <= 1'b0;
        end
    end

endmodule

// File: rtl/ostmr_wdog_fsm.sv
module ostmr_wdog_fsm
    import ostmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic arm_req,
    input  logic trip_hit,
    output logic armed,
    output logic tripped
);

    wd_state_t state_q;
    wd_state_t state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WD_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: ARM (idle -> armed), TRIP (armed -> tripped)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WD_IDLE:    if (arm_req)  state_d = WD_ARMED;
            WD_ARMED:   if (trip_hit) state_d = WD_TRIPPED;
            WD_TRIPPED: state_d = WD_TRIPPED;
            default:    state_d = WD_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        armed   = 1'b0;
        tripped = 1'b0;
        unique case (state_q)
            WD_IDLE:    ;
            WD_ARMED:   armed = 1'b1;
            WD_TRIPPED: begin
                armed   = 1'b1;
                tripped = 1'b1;
            end
            default:    ;
        endcase
    end

endmodule

// File: rtl/os_timer_wdog.sv
module os_timer_wdog
    import ostmr_pkg::*;
#(
    parameter int               CNT_W     = 32,
    parameter logic [CNT_W-1:0] MATCH_RST = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic [NUM_CH-1:0] irq,
    output logic              rst_req
);

    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  cnt_nxt;
    logic [CNT_W-1:0]  match_q [NUM_CH];
    logic [NUM_CH-1:0] hit;
    logic [NUM_CH-1:0] status;
    logic [NUM_CH-1:0] irq_en_q;
    logic              wd_armed;
    logic              wd_tripped;
    logic              wr_status;
    logic              wr_irqen;
    logic              wr_wdctl;

    assign wr_status = bus_wr && (bus_addr == A_STATUS);
    assign wr_irqen  = bus_wr && (bus_addr == A_IRQEN);
    assign wr_wdctl  = bus_wr && (bus_addr == A_WDCTL);

    ostmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (tick),
        .cnt_q   (cnt_q),
        .cnt_nxt (cnt_nxt)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        ostmr_match_ch #(
            .CNT_W     (CNT_W),
            .MATCH_RST (MATCH_RST)
        ) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .step     (tick),
            .cnt_nxt  (cnt_nxt),
            .wr_match (bus_wr && (bus_addr == ADDR_W'(i))),
            .wdata    (bus_wdata),
            .clr      (wr_status && bus_wdata[i]),
            .match_q  (match_q[i]),
            .hit      (hit[i]),
            .status   (status[i])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_en_q <= '0;
        end else if (wr_irqen) begin
            irq_en_q <= bus_wdata[NUM_CH-1:0];
        end
    end

    ostmr_wdog_fsm u_wd (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm_req  (wr_wdctl && bus_wdata[0]),
        .trip_hit (hit[WD_CH]),
        .armed    (wd_armed),
        .tripped  (wd_tripped)
    );

    assign irq     = status & irq_en_q;
    assign rst_req = wd_tripped;

    always_comb begin
        bus_rdata = '0;
        for (int k = 0; k < NUM_CH; k++) begin
            if (bus_addr == ADDR_W'(k)) bus_rdata = match_q[k];
        end
        unique case (bus_addr)
            A_COUNT:  bus_rdata = cnt_q;
            A_STATUS: bus_rdata = CNT_W'(status);
            A_IRQEN:  bus_rdata = CNT_W'(irq_en_q);
            A_WDCTL:  bus_rdata = CNT_W'({wd_tripped, wd_armed});
            default:  ;
        endcase
    end

endmodule

// File: rtl/ostmr_checker.sv
module ostmr_checker
    import ostmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [CNT_W-1:0]  bus_wdata,
    input logic [CNT_W-1:0]  cnt_q,
    input logic [CNT_W-1:0]  match_q [NUM_CH],
    input logic [NUM_CH-1:0] status,
    input logic [NUM_CH-1:0] irq_en_q,
    input logic [NUM_CH-1:0] irq,
    input logic              wd_armed,
    input logic              rst_req
);

    p_cnt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt_q));

    p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        p_status_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (tick && (cnt_q + CNT_W'(1) == match_q[i])) |=> status[i]);

        p_status_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == A_STATUS && bus_wdata[i]
             && !(tick && (cnt_q + CNT_W'(1) == match_q[i]))) |=> !status[i]);
    end

    p_irq_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq & ~irq_en_q) == '0);

    p_arm_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wd_armed |=> wd_armed);

    p_trip_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_armed && tick && (cnt_q + CNT_W'(1) == match_q[WD_CH])) |=> rst_req);

    p_trip_needs_arm_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req) |-> $past(wd_armed));

    p_req_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> rst_req);

endmodule

bind os_timer_wdog ostmr_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .cnt_q     (cnt_q),
    .match_q   (match_q),
    .status    (status),
    .irq_en_q  (irq_en_q),
    .irq       (irq),
    .wd_armed  (wd_armed),
    .rst_req   (rst_req)
);

// File: tb/os_timer_wdog_tb.sv
module os_timer_wdog_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic [3:0]  irq;
    logic        rst_req;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] exp_cnt = 0;

    always #10 clk = ~clk;

    os_timer_wdog u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq),
        .rst_req   (rst_req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        exp_cnt = 0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            tick = 1'b1;
            exp_cnt = exp_cnt + 1;
        end
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic t_reset();
        for (int a = 0; a < 4; a++) rd_chk(3'(a), 32'hFFFF_FFFF, "R1 compare reset");
        rd_chk(3'd4, 32'd0, "R1 count reset");
        rd_chk(3'd5, 32'd0, "R1 status reset");
        rd_chk(3'd6, 32'd0, "R1 enable reset");
        rd_chk(3'd7, 32'd0, "R1 wdog ctl reset");
        chk("R1 irq reset", 32'(irq), 32'd0);
        chk("R1 rst_req reset", 32'(rst_req), 32'd0);
    endtask

    task automatic t_count();
        ticks(7);
        rd_chk(3'd4, exp_cnt, "R2 count after 7 ticks");
        repeat (5) @(negedge clk);
        rd_chk(3'd4, exp_cnt, "R2 count holds without tick");
        wr(3'd4, 32'h0000_1234);
        rd_chk(3'd4, exp_cnt, "R2 count write ignored");
    endtask

    task automatic t_match_rw();
        wr(3'd0, 32'hA5A5_0001);
        wr(3'd2, 32'hFFFF_0000);
        rd_chk(3'd0, 32'hA5A5_0001, "R3 compare0 readback");
        rd_chk(3'd2, 32'hFFFF_0000, "R3 compare2 readback");
    endtask

    task automatic t_status();
        wr(3'd1, exp_cnt + 3);
        ticks(2);
        rd_chk(3'd5, 32'h0, "R4 no status before match");
        ticks(1);
        rd_chk(3'd5, 32'h2, "R4 status on match");
        chk("R6 irq masked when disabled", 32'(irq), 32'h0);
        ticks(3);
        rd_chk(3'd5, 32'h2, "R4 status sticky");
        wr(3'd6, 32'h2);
        chk("R6 irq with enable", 32'(irq), 32'h2);
        wr(3'd5, 32'h1);
        rd_chk(3'd5, 32'h2, "R5 zero bit leaves status");
        wr(3'd5, 32'h2);
        rd_chk(3'd5, 32'h0, "R5 write-one clears");
        chk("R6 irq drops after clear", 32'(irq), 32'h0);
    endtask

    task automatic t_set_beats_clear();
        wr(3'd2, exp_cnt + 2);
        ticks(1);
        @(negedge clk);
        tick = 1'b1; bus_wr = 1'b1; bus_addr = 3'd5; bus_wdata = 32'h4;
        exp_cnt = exp_cnt + 1;
        @(negedge clk);
        tick = 1'b0; bus_wr = 1'b0;
        rd_chk(3'd5, 32'h4, "R5 hit beats same-cycle clear");
        wr(3'd5, 32'h4);
        rd_chk(3'd5, 32'h0, "R5 later clear works");
    endtask

    task automatic t_wdog_unarmed();
        wr(3'd3, exp_cnt + 2);
        ticks(2);
        rd_chk(3'd5, 32'h8, "R8 unarmed hit sets status3");
        chk("R8 unarmed hit no reset", 32'(rst_req), 32'd0);
        rd_chk(3'd7, 32'h0, "R7 still idle");
        wr(3'd5, 32'h8);
    endtask

    task automatic t_wdog_trip();
        wr(3'd7, 32'h1);
        rd_chk(3'd7, 32'h1, "R7 armed");
        wr(3'd7, 32'h0);
        rd_chk(3'd7, 32'h1, "R7 cannot disarm");
        wr(3'd3, exp_cnt + 3);
        ticks(2);
        chk("R8 no reset before match", 32'(rst_req), 32'd0);
        ticks(1);
        chk("R8 reset on armed match", 32'(rst_req), 32'd1);
        rd_chk(3'd7, 32'h3, "R7 tripped readback");
        repeat (6) @(negedge clk);
        chk("R8 reset request held", 32'(rst_req), 32'd1);
        do_reset();
        @(negedge clk);
        chk("R8 reset clears request", 32'(rst_req), 32'd0);
        rd_chk(3'd7, 32'h0, "R1 ctl idle after reset");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        do_reset();
        t_reset();
        t_count();
        t_match_rw();
        t_status();
        t_set_beats_clear();
        t_wdog_unarmed();
        t_wdog_trip();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule